// File: doc/BRIEF.md
# Two-Way Integer/FP Pair Issue Control

This block is the issue-stage decision logic of an in-order, two-wide pipeline. Each cycle the fetch stage presents a group of two decoded instructions. The left slot may hold any instruction class. The right slot is meant for a floating-point operation. From these the block decides whether nothing issues, the left instruction issues alone, or both issue together. It reports how many slots the fetch stage must consume: 0, 1 or 2.

When only the left instruction issues, the fetch side shifts the held right instruction into the left position for the next cycle. Hazards are detected in two ways:
- Against the left instruction of the same group, which creates a same-cycle RAW dependence.
- Against a small scoreboard of loads issued in recent cycles. With the default delay of one cycle, a load's result cannot be read by the right instruction of its own group, nor by either instruction of the group that follows it.

Register index 0 means "no operand" or "no write". Register indices share one space: integer registers are low and FP registers are high. Instruction class is a 2-bit code:
- 0 = integer op
- 1 = load (integer or FP)
- 2 = FP operation
- 3 = store (never writes)

Top module: `pair_iss_ctl`

## Requirements
- R1: While `stall` is 1, `l_issue`, `r_issue` are 0 and `adv` is 0; the load delay is counted in cycles, so a stalled cycle still ends a load's shadow.
- R2: A valid left instruction that is not stalled and reads no register in the load shadow issues, whatever its class (0..3).
- R3: `r_issue` is 1 only in a cycle where `l_issue` is 1.
- R4: The right instruction issues only if its class is 2 (FP operation) and the left class is not 2; two integer-side or two FP operations never pair.
- R5: A right instruction with a source equal to the left instruction's nonzero destination does not issue that cycle.
- R6: A left instruction of class 1 with a nonzero destination makes that register unreadable by either slot in the next cycle; two cycles later it may be read freely.
- R7: Register index 0 never causes a hazard, either as a source or as a destination.
- R8: `adv` is 2 when both issue, 1 when only the left issues, and 0 when nothing issues.
- R9: A load on the left with an independent FP operation on the right issues as a pair.
- R10: After reset the load scoreboard is empty, and no issue flag is raised while `rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Downstream stall, blocks all issue |
| l_vld | input | 1 | Left slot holds an instruction |
| l_cls | input | 2 | Left class code |
| l_dst | input | REG_W | Left destination (0 = none) |
| l_src0 | input | REG_W | Left first source (0 = none) |
| l_src1 | input | REG_W | Left second source (0 = none) |
| r_vld | input | 1 | Right slot holds an instruction |
| r_cls | input | 2 | Right class code |
| r_src0 | input | REG_W | Right first source (0 = none) |
| r_src1 | input | REG_W | Right second source (0 = none) |
| l_issue | output | 1 | Left instruction issues this cycle |
| r_issue | output | 1 | Right instruction issues this cycle |
| adv | output | 2 | Slots consumed from the fetch group |

## Verification
The hardest situation to reach is a load shadow that overlaps another condition that also blocks issue, such as a stall, a same-group RAW dependence or an illegal class pair. In that case the blocking cause for each slot must be told apart. Each swept vector is therefore preceded by a setup cycle that either issues a load into a fixed register or issues a harmless integer op. The test group is then applied with every class pair, each source selection, both destination choices and both stall levels. Directed sequences follow a load with an empty or stalled cycle, and then show that the reader issues once the shadow has passed.

// File: rtl/pair_iss_pkg.sv
`timescale 1ns/1ps
package pair_iss_pkg;
  typedef enum logic [1:0] {
    CLS_INT   = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_FPOP  = 2'd2,
    CLS_STORE = 2'd3
  } iclass_e;
endpackage

// File: rtl/pair_iss_haz.sv
`timescale 1ns/1ps
// Compares two source indices against a list of pending destinations.
module pair_iss_haz #(
  parameter int REG_W = 6,
  parameter int DEPTH = 1
) (
  input  logic [REG_W-1:0]       src0,
  input  logic [REG_W-1:0]       src1,
  input  logic [DEPTH*REG_W-1:0] pend,
  output logic                   hit
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [REG_W-1:0] d;
    assign d = pend[g*REG_W +: REG_W];
    assign match[g] = (d != '0) && ((src0 == d) || (src1 == d));
  end

  assign hit = |match;
endmodule

// File: rtl/pair_iss_sb.sv
`timescale 1ns/1ps
// Shift chain of load destinations still inside their delay window.
module pair_iss_sb #(
  parameter int REG_W = 6,
  parameter int DEPTH = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_fire,
  input  logic [REG_W-1:0]       ld_dst,
  output logic [DEPTH*REG_W-1:0] pend
);
  logic [REG_W-1:0] ent_q [DEPTH];
  logic [REG_W-1:0] ent_d [DEPTH];

  always_comb begin
    ent_d[0] = ld_fire ? ld_dst : '0;
    for (int i = 1; i < DEPTH; i++) ent_d[i] = ent_q[i-1];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= '0;
      else        ent_q[g] <= ent_d[g];
    end
    assign pend[g*REG_W +: REG_W] = ent_q[g];
  end
endmodule

// File: rtl/pair_iss_ctl.sv
`timescale 1ns/1ps
module pair_iss_ctl
  import pair_iss_pkg::*;
#(
  parameter int REG_W    = 6,
  parameter int LOAD_DLY = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             l_vld,
  input  logic [1:0]       l_cls,
  input  logic [REG_W-1:0] l_dst,
  input  logic [REG_W-1:0] l_src0,
  input  logic [REG_W-1:0] l_src1,
  input  logic             r_vld,
  input  logic [1:0]       r_cls,
  input  logic [REG_W-1:0] r_src0,
  input  logic [REG_W-1:0] r_src1,
  output logic             l_issue,
  output logic             r_issue,
  output logic [1:0]       adv
);
  localparam int SBW = LOAD_DLY * REG_W;

  logic [SBW-1:0] pend;
  logic           l_shadow, r_shadow, r_raw;
  logic           pair_ok, go;

  pair_iss_sb #(.REG_W(REG_W), .DEPTH(LOAD_DLY)) i_sb (
    .clk(clk), .rst_n(rst_n),
    .ld_fire(l_issue && (l_cls == CLS_LOAD)),
    .ld_dst(l_dst), .pend(pend)
  );

  pair_iss_haz #(.REG_W(REG_W), .DEPTH(LOAD_DLY)) i_haz_l (
    .src0(l_src0), .src1(l_src1), .pend(pend), .hit(l_shadow)
  );
  pair_iss_haz #(.REG_W(REG_W), .DEPTH(LOAD_DLY)) i_haz_r (
    .src0(r_src0), .src1(r_src1), .pend(pend), .hit(r_shadow)
  );
  pair_iss_haz #(.REG_W(REG_W), .DEPTH(1)) i_haz_raw (
    .src0(r_src0), .src1(r_src1), .pend(l_dst), .hit(r_raw)
  );

  assign go      = rst_n && !stall;
  assign pair_ok = (r_cls == CLS_FPOP) && (l_cls != CLS_FPOP);

  always_comb begin
    l_issue = go && l_vld && !l_shadow;
    r_issue = l_issue && r_vld && pair_ok && !r_raw && !r_shadow;
    adv     = r_issue ? 2'd2 : (l_issue ? 2'd1 : 2'd0);
  end

  p_stall_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!l_issue && !r_issue && adv == 2'd0));

  p_right_after_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    r_issue |-> l_issue);

  p_pair_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    r_issue |-> (r_cls == CLS_FPOP && l_cls != CLS_FPOP));

  p_same_group_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (l_dst != '0 && (r_src0 == l_dst || r_src1 == l_dst)) |-> !r_issue);

  p_load_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(l_issue && l_cls == CLS_LOAD && l_dst != '0) &&
     (l_src0 == $past(l_dst) || l_src1 == $past(l_dst))) |-> !l_issue);

  p_adv_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv == 2'd2) |-> r_issue);
endmodule

// File: tb/test_pair_iss_ctl.sv
`timescale 1ns/1ps
module test_pair_iss_ctl;
  localparam int RW = 6;
  localparam logic [RW-1:0] LDR = 6'd40;

  logic clk = 1'b0, rst_n = 1'b0, stall = 1'b0;
  logic l_vld = 1'b0, r_vld = 1'b0;
  logic [1:0] l_cls = 2'd0, r_cls = 2'd0;
  logic [RW-1:0] l_dst = '0, l_src0 = '0, l_src1 = '0, r_src0 = '0, r_src1 = '0;
  logic l_issue, r_issue;
  logic [1:0] adv;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pair_iss_ctl #(.REG_W(RW), .LOAD_DLY(1)) i_pair_iss_ctl (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .l_vld(l_vld), .l_cls(l_cls), .l_dst(l_dst), .l_src0(l_src0), .l_src1(l_src1),
    .r_vld(r_vld), .r_cls(r_cls), .r_src0(r_src0), .r_src1(r_src1),
    .l_issue(l_issue), .r_issue(r_issue), .adv(adv));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit lv, input logic [1:0] lc, input logic [RW-1:0] ld,
                       input logic [RW-1:0] ls0, input logic [RW-1:0] ls1,
                       input bit rv, input logic [1:0] rc,
                       input logic [RW-1:0] rs0, input logic [RW-1:0] rs1, input bit st);
    l_vld = lv; l_cls = lc; l_dst = ld; l_src0 = ls0; l_src1 = ls1;
    r_vld = rv; r_cls = rc; r_src0 = rs0; r_src1 = rs1; stall = st;
  endtask

  task automatic expect3(input string tag, input bit le, input bit re);
    #1;
    chk({tag, " l_issue"}, int'(l_issue), int'(le));
    chk({tag, " r_issue"}, int'(r_issue), int'(re));
    chk({"R8 ", tag, " adv"}, int'(adv), re ? 2 : (le ? 1 : 0));
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    // R10: no issue while in reset
    drive(1, 2'd0, 6'd5, LDR, 0, 1, 2'd2, LDR, 0, 0);
    #1;
    chk("R10 reset l_issue", int'(l_issue), 0);
    chk("R10 reset r_issue", int'(r_issue), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R10: empty scoreboard, readers of LDR issue as a pair
    expect3("R10 post-reset", 1, 1);
    @(posedge clk);

    // Sweep
    for (int pl = 0; pl < 2; pl++)
      for (int lc = 0; lc < 4; lc++)
        for (int rc = 0; rc < 4; rc++)
          for (int lss = 0; lss < 3; lss++)
            for (int rss = 0; rss < 4; rss++)
              for (int dsel = 0; dsel < 2; dsel++)
                for (int st = 0; st < 2; st++) begin
                  logic [RW-1:0] ldst, lsrc, rsrc;
                  bit le, re, lh, rh, raw, legal;
                  string tag;
                  ldst = dsel ? 6'd33 : 6'd0;
                  lsrc = (lss == 0) ? 6'd0 : ((lss == 1) ? LDR : 6'd9);
                  rsrc = (rss == 0) ? 6'd0 : ((rss == 1) ? LDR : ((rss == 2) ? ldst : 6'd35));
                  @(negedge clk);
                  if (pl != 0) drive(1, 2'd1, LDR, 0, 0, 0, 2'd0, 0, 0, 0);
                  else         drive(1, 2'd0, 6'd7, 0, 0, 0, 2'd0, 0, 0, 0);
                  @(negedge clk);
                  drive(1, lc[1:0], ldst, lsrc, 6'd3, 1, rc[1:0], 6'd34, rsrc, st[0]);
                  lh    = (pl != 0) && (lsrc == LDR);
                  rh    = (pl != 0) && (rsrc == LDR);
                  raw   = (ldst != 0) && (rsrc == ldst);
                  legal = (rc == 2) && (lc != 2);
                  le    = !st[0] && !lh;
                  re    = le && legal && !raw && !rh;
                  if (st != 0)                      tag = "R1";
                  else if (lh || rh)                tag = "R6";
                  else if (raw)                     tag = "R5";
                  else if (rss == 2 && dsel == 0)   tag = "R7";
                  else if (lc == 1 && rc == 2)      tag = "R9";
                  else if (!legal)                  tag = "R4";
                  else                              tag = "R2/R3";
                  expect3(tag, le, re);
                end

    // R6: shadow ends after one cycle (empty group between)
    @(negedge clk) drive(1, 2'd1, LDR, 0, 0, 0, 2'd0, 0, 0, 0);
    @(negedge clk) drive(0, 2'd0, 0, 0, 0, 0, 2'd0, 0, 0, 0);
    @(negedge clk) drive(1, 2'd0, 6'd4, LDR, 0, 1, 2'd2, LDR, 0, 0);
    expect3("R6 two cycles later", 1, 1);

    // R1: stalled cycle still retires the shadow
    @(negedge clk) drive(1, 2'd1, LDR, 0, 0, 0, 2'd0, 0, 0, 0);
    @(negedge clk) drive(1, 2'd0, 6'd4, LDR, 0, 1, 2'd2, 0, 0, 1);
    expect3("R1 stall after load", 0, 0);
    @(negedge clk) stall = 1'b0;
    expect3("R1 reader after stall", 1, 1);

    // R9: FP load left, FP op right reading other FP regs
    @(negedge clk) drive(1, 2'd1, 6'd50, 6'd2, 0, 1, 2'd2, 6'd51, 6'd52, 0);
    expect3("R9 load+fpop", 1, 1);

    // R6/R3: right held alone: left issues, right reads load dst -> left only
    @(negedge clk) drive(1, 2'd1, 6'd50, 6'd2, 0, 1, 2'd2, 6'd50, 0, 0);
    expect3("R5 load feeds right", 1, 0);
    // held right becomes left next cycle, still in shadow
    @(negedge clk) drive(1, 2'd2, 6'd53, 6'd50, 0, 0, 2'd0, 0, 0, 0);
    expect3("R6 held right in shadow", 0, 0);
    @(negedge clk) drive(1, 2'd2, 6'd53, 6'd50, 0, 0, 2'd0, 0, 0, 0);
    expect3("R6 held right after shadow", 1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule